// File: doc/BRIEF.md
# Dense-Bank Tag Directory Filter

This block is a small presence directory that lives beside a fast cache bank and keeps a copy of the tags held by one paired dense (slow, high-capacity) bank. Whenever a request arrives at the fast bank, the same line address is presented to the filter. Because the filter answers in the same cycle the fast bank is read, the lookup stays off the critical path. If the tag is present, the request is forwarded to the dense bank. If it is absent, the request is dropped, so the dense bank is never woken for a line it cannot hold. As a result, a full search activates every fast bank but at most one dense bank.

The dense bank reports each line it installs and each line it removes through an update port. The filter applies the change and then acknowledges it, and the dense bank treats its own operation as finished only once that acknowledge arrives. The storage is indexed directly by set, with a configurable number of ways, and every entry holds a valid flag and an address tag. An update and a lookup that target the same set in the same cycle cannot both proceed. The update wins, and the lookup is held off for one cycle.

Top module: `tagDirFilter`

## Requirements
- R1: After reset every entry is invalid; every lookup is dropped until the first successful allocate, and fwdValid, dropValid, updDone and updErr are low.
- R2: A lookup accepted at a clock edge (lkValid high, lkStall low) produces, in the following cycle, exactly one of fwdValid or dropValid, with rspAddr equal to the looked-up address; with no accepted lookup both stay low.
- R3: A lookup of a line address that has been allocated and not deallocated raises fwdValid.
- R4: A lookup whose tag is not present in its set raises dropValid, including a different tag that maps to an occupied set.
- R5: A deallocate of a present line removes it; later lookups of that line are dropped and the freed way can be allocated again.
- R6: An allocate to a set whose ways are all valid is rejected with updErr and changes nothing: the new line stays absent and the resident lines still hit.
- R7: An allocate of a line already present is rejected with updErr and leaves one copy, so a single deallocate makes it absent.
- R8: A deallocate of a line that is not present is rejected with updErr and changes nothing.
- R9: When an update and a lookup to the same set are both valid in one cycle, lkStall is high and the lookup is not accepted (no response next cycle); held one more cycle, it is accepted and sees the update.
- R10: An update and a lookup to different sets in the same cycle proceed together without a stall.
- R11: Every update command is acknowledged by updDone exactly one cycle later; updErr is only ever high together with updDone.
- R12: Up to WAYS distinct tags of one set coexist and all hit. The set index is the low log2(SETS) bits of the line address, and the tag is the remaining upper bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lkValid | input | 1 | Lookup request from the fast-bank path |
| lkAddr | input | ADDR_W | Line address of the lookup |
| lkStall | output | 1 | Lookup not accepted this cycle (same-set update) |
| fwdValid | output | 1 | Previous accepted lookup hit: forward to dense bank |
| dropValid | output | 1 | Previous accepted lookup missed: request dropped |
| rspAddr | output | ADDR_W | Address of the answered lookup |
| updValid | input | 1 | Update command from the dense bank |
| updAlloc | input | 1 | 1 = allocate, 0 = deallocate |
| updAddr | input | ADDR_W | Line address being allocated or removed |
| updDone | output | 1 | Update acknowledged (one cycle after command) |
| updErr | output | 1 | Update rejected (full set, duplicate or absent line) |

## Verification
The hardest situation to reach is the same-cycle collision between an update and a lookup that target the same set. The stimulus produces it by presenting both commands on one falling edge, with the addresses built from an identical set index. The bench then holds the lookup for a second cycle, which shows both that the stalled cycle returned nothing and that the retried lookup sees the freshly installed line. A full set is reached by allocating WAYS distinct tags into one index before the rejected allocate is tried.

// File: rtl/tdfPkg.sv
package tdfPkg;
  // Strobes passed from control to datapath for one cycle
  typedef struct packed {
    logic lkAccept;  // capture a lookup result this edge
    logic wrEn;      // write the selected way of the update set
    logic wrValid;   // value written to the valid flag
    logic updCmd;    // an update command is present
    logic updBad;    // the update command is rejected
  } tdfStrobeT;
endpackage

// File: rtl/tdfCtrl.sv
module tdfCtrl
  import tdfPkg::*;
#(
  parameter int WAYS  = 4,
  parameter int SET_W = 8
) (
  input  logic             lkValid,
  input  logic [SET_W-1:0] lkSet,
  input  logic             updValid,
  input  logic             updAlloc,
  input  logic [SET_W-1:0] updSet,
  input  logic [WAYS-1:0]  updMatch,
  input  logic [WAYS-1:0]  updFree,
  output logic             lkStall,
  output logic [WAYS-1:0]  wrWayOh,
  output tdfStrobeT        st
);
  logic sameSet;
  logic anyMatch;
  logic anyFree;
  logic updOk;
  logic [WAYS-1:0] freeLowOh;

  assign sameSet   = lkValid && updValid && (lkSet == updSet);
  assign anyMatch  = |updMatch;
  assign anyFree   = |updFree;
  // lowest-index free way as a one-hot vector
  assign freeLowOh = updFree & (~updFree + WAYS'(1));

  always_comb begin
    if (updAlloc) begin
      updOk   = anyFree && !anyMatch;
      wrWayOh = freeLowOh;
    end else begin
      updOk   = anyMatch;
      wrWayOh = updMatch;
    end
  end

  assign lkStall     = sameSet;
  assign st.lkAccept = lkValid && !sameSet;
  assign st.wrEn     = updValid && updOk;
  assign st.wrValid  = updAlloc;
  assign st.updCmd   = updValid;
  assign st.updBad   = updValid && !updOk;
endmodule

// File: rtl/tdfDatapath.sv
module tdfDatapath
  import tdfPkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int SETS   = 256,
  parameter int WAYS   = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int TAG_W = ADDR_W - SET_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] lkAddr,
  input  logic [ADDR_W-1:0] updAddr,
  input  tdfStrobeT         st,
  input  logic [WAYS-1:0]   wrWayOh,
  output logic [SET_W-1:0]  lkSet,
  output logic [SET_W-1:0]  updSet,
  output logic [WAYS-1:0]   updMatch,
  output logic [WAYS-1:0]   updFree,
  output logic              fwdValid,
  output logic              dropValid,
  output logic [ADDR_W-1:0] rspAddr,
  output logic              updDone,
  output logic              updErr
);
  logic [TAG_W-1:0] tagMem [SETS][WAYS];
  logic [WAYS-1:0]  vldMem [SETS];

  logic [TAG_W-1:0] lkTag;
  logic [TAG_W-1:0] updTag;
  logic [WAYS-1:0]  lkHitVec;
  logic             lkHit;

  assign lkSet  = lkAddr[SET_W-1:0];
  assign lkTag  = lkAddr[ADDR_W-1:SET_W];
  assign updSet = updAddr[SET_W-1:0];
  assign updTag = updAddr[ADDR_W-1:SET_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign lkHitVec[w] = vldMem[lkSet][w] && (tagMem[lkSet][w] == lkTag);
    assign updMatch[w] = vldMem[updSet][w] && (tagMem[updSet][w] == updTag);
    assign updFree[w]  = !vldMem[updSet][w];
  end

  assign lkHit = |lkHitVec;

  // valid flags: cleared by reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) vldMem[s] <= '0;
    end else if (st.wrEn) begin
      for (int w = 0; w < WAYS; w++)
        if (wrWayOh[w]) vldMem[updSet][w] <= st.wrValid;
    end
  end

  // tags: written only on allocate, no reset needed
  always_ff @(posedge clk) begin
    if (st.wrEn && st.wrValid) begin
      for (int w = 0; w < WAYS; w++)
        if (wrWayOh[w]) tagMem[updSet][w] <= updTag;
    end
  end

  // response registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fwdValid  <= 1'b0;
      dropValid <= 1'b0;
      rspAddr   <= '0;
      updDone   <= 1'b0;
      updErr    <= 1'b0;
    end else begin
      fwdValid  <= st.lkAccept && lkHit;
      dropValid <= st.lkAccept && !lkHit;
      if (st.lkAccept) rspAddr <= lkAddr;
      updDone   <= st.updCmd;
      updErr    <= st.updBad;
    end
  end
endmodule

// File: rtl/tagDirFilter.sv
module tagDirFilter
  import tdfPkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int SETS   = 256,
  parameter int WAYS   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lkValid,
  input  logic [ADDR_W-1:0] lkAddr,
  output logic              lkStall,
  output logic              fwdValid,
  output logic              dropValid,
  output logic [ADDR_W-1:0] rspAddr,
  input  logic              updValid,
  input  logic              updAlloc,
  input  logic [ADDR_W-1:0] updAddr,
  output logic              updDone,
  output logic              updErr
);
  localparam int SET_W = $clog2(SETS);

  tdfStrobeT        st;
  logic [WAYS-1:0]  wrWayOh;
  logic [SET_W-1:0] lkSet;
  logic [SET_W-1:0] updSet;
  logic [WAYS-1:0]  updMatch;
  logic [WAYS-1:0]  updFree;

  tdfCtrl #(.WAYS(WAYS), .SET_W(SET_W)) u_ctrl (
    .lkValid (lkValid),
    .lkSet   (lkSet),
    .updValid(updValid),
    .updAlloc(updAlloc),
    .updSet  (updSet),
    .updMatch(updMatch),
    .updFree (updFree),
    .lkStall (lkStall),
    .wrWayOh (wrWayOh),
    .st      (st)
  );

  tdfDatapath #(.ADDR_W(ADDR_W), .SETS(SETS), .WAYS(WAYS)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .lkAddr   (lkAddr),
    .updAddr  (updAddr),
    .st       (st),
    .wrWayOh  (wrWayOh),
    .lkSet    (lkSet),
    .updSet   (updSet),
    .updMatch (updMatch),
    .updFree  (updFree),
    .fwdValid (fwdValid),
    .dropValid(dropValid),
    .rspAddr  (rspAddr),
    .updDone  (updDone),
    .updErr   (updErr)
  );
endmodule

// File: rtl/tdfChecker.sv
module tdfChecker #(
  parameter int ADDR_W = 26
) (
  input logic              clk,
  input logic              rstN,
  input logic              lkValid,
  input logic [ADDR_W-1:0] lkAddr,
  input logic              lkStall,
  input logic              fwdValid,
  input logic              dropValid,
  input logic [ADDR_W-1:0] rspAddr,
  input logic              updValid,
  input logic              updAlloc,
  input logic              updDone,
  input logic              updErr
);
  logic allocSeen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) allocSeen <= 1'b0;
    else if (updValid && updAlloc) allocSeen <= 1'b1;
  end

  // R1
  no_early_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    !allocSeen |-> !fwdValid);
  // R2
  resp_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lkValid && !lkStall) |=> (fwdValid || dropValid));
  // R2
  resp_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({fwdValid, dropValid}));
  // R2
  resp_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lkValid && !lkStall) |=> (rspAddr == $past(lkAddr)));
  // R2
  no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lkValid |=> !(fwdValid || dropValid));
  // R9
  stall_noresp_chk: assert property (@(posedge clk) disable iff (!rstN)
    lkStall |=> !(fwdValid || dropValid));
  // R9
  stall_needs_upd_chk: assert property (@(posedge clk) disable iff (!rstN)
    lkStall |-> (updValid && lkValid));
  // R11
  upd_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    updValid |=> updDone);
  // R11
  no_spurious_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    !updValid |=> !updDone);
  // R11
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    updErr |-> updDone);
endmodule

bind tagDirFilter tdfChecker #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .lkValid  (lkValid),
  .lkAddr   (lkAddr),
  .lkStall  (lkStall),
  .fwdValid (fwdValid),
  .dropValid(dropValid),
  .rspAddr  (rspAddr),
  .updValid (updValid),
  .updAlloc (updAlloc),
  .updDone  (updDone),
  .updErr   (updErr)
);

// File: tb/tb_tagDirFilter.sv
module tb_tagDirFilter;
  localparam int ADDR_W = 26;
  localparam int SETS   = 256;
  localparam int WAYS   = 4;
  localparam int SET_W  = 8;
  localparam int TAG_W  = ADDR_W - SET_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lkValid = 1'b0;
  logic [ADDR_W-1:0] lkAddr = '0;
  logic lkStall, fwdValid, dropValid, updDone, updErr;
  logic [ADDR_W-1:0] rspAddr;
  logic updValid = 1'b0;
  logic updAlloc = 1'b0;
  logic [ADDR_W-1:0] updAddr = '0;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  tagDirFilter #(.ADDR_W(ADDR_W), .SETS(SETS), .WAYS(WAYS)) dut (
    .clk(clk), .rstN(rstN),
    .lkValid(lkValid), .lkAddr(lkAddr), .lkStall(lkStall),
    .fwdValid(fwdValid), .dropValid(dropValid), .rspAddr(rspAddr),
    .updValid(updValid), .updAlloc(updAlloc), .updAddr(updAddr),
    .updDone(updDone), .updErr(updErr)
  );

  function automatic logic [ADDR_W-1:0] mk(input int tag, input int set);
    return {TAG_W'(tag), SET_W'(set)};
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one update; checks acknowledge and error one cycle later
  task automatic doUpd(input string req, input logic alloc,
                       input logic [ADDR_W-1:0] a, input logic expErr);
    @(negedge clk);
    updValid = 1'b1; updAlloc = alloc; updAddr = a;
    @(negedge clk);
    updValid = 1'b0;
    chk("R11", "updDone", updDone, 1);
    chk(req, "updErr", updErr, expErr);
  endtask

  // one lookup; checks no stall and forward/drop next cycle
  task automatic doLk(input string req, input logic [ADDR_W-1:0] a,
                      input logic expHit);
    @(negedge clk);
    lkValid = 1'b1; lkAddr = a;
    #1 chk(req, "lkStall", lkStall, 0);
    @(negedge clk);
    lkValid = 1'b0;
    chk(req, "fwdValid", fwdValid, expHit);
    chk(req, "dropValid", dropValid, !expHit);
    chk("R2", "rspAddr", rspAddr, a);
  endtask

  task automatic testReset();
    chk("R1", "fwdValid", fwdValid, 0);
    chk("R1", "dropValid", dropValid, 0);
    chk("R1", "updDone", updDone, 0);
    chk("R1", "updErr", updErr, 0);
    doLk("R1", mk(0, 0), 0);
    doLk("R1", mk(7, 200), 0);
    @(negedge clk);
    chk("R2", "idle fwd", fwdValid, 0);
    chk("R2", "idle drop", dropValid, 0);
  endtask

  task automatic testHitMiss();
    doUpd("R3", 1, mk(11, 3), 0);
    doLk("R3", mk(11, 3), 1);
    doLk("R4", mk(12, 3), 0);
    doLk("R4", mk(11, 4), 0);
  endtask

  task automatic testFullSet();
    for (int t = 1; t <= WAYS; t++) doUpd("R12", 1, mk(100 + t, 5), 0);
    for (int t = 1; t <= WAYS; t++) doLk("R12", mk(100 + t, 5), 1);
    doUpd("R6", 1, mk(200, 5), 1);
    doLk("R6", mk(200, 5), 0);
    for (int t = 1; t <= WAYS; t++) doLk("R6", mk(100 + t, 5), 1);
  endtask

  task automatic testDealloc();
    doUpd("R5", 0, mk(102, 5), 0);
    doLk("R5", mk(102, 5), 0);
    doLk("R5", mk(101, 5), 1);
    doUpd("R5", 1, mk(200, 5), 0);
    doLk("R5", mk(200, 5), 1);
  endtask

  task automatic testDup();
    doUpd("R7", 1, mk(50, 9), 0);
    doUpd("R7", 1, mk(50, 9), 1);
    doUpd("R7", 0, mk(50, 9), 0);
    doLk("R7", mk(50, 9), 0);
    doUpd("R8", 0, mk(50, 9), 1);
    doUpd("R8", 0, mk(77, 3), 1);
    doLk("R8", mk(11, 3), 1);
  endtask

  task automatic testSameSet();
    @(negedge clk);
    updValid = 1'b1; updAlloc = 1'b1; updAddr = mk(60, 20);
    lkValid = 1'b1; lkAddr = mk(60, 20);
    #1 chk("R9", "lkStall", lkStall, 1);
    @(negedge clk);
    updValid = 1'b0;
    chk("R9", "stalled fwd", fwdValid, 0);
    chk("R9", "stalled drop", dropValid, 0);
    chk("R11", "updDone", updDone, 1);
    #1 chk("R9", "lkStall released", lkStall, 0);
    @(negedge clk);
    lkValid = 1'b0;
    chk("R9", "retry fwd", fwdValid, 1);
  endtask

  task automatic testDiffSet();
    @(negedge clk);
    updValid = 1'b1; updAlloc = 1'b1; updAddr = mk(61, 21);
    lkValid = 1'b1; lkAddr = mk(60, 20);
    #1 chk("R10", "lkStall", lkStall, 0);
    @(negedge clk);
    updValid = 1'b0; lkValid = 1'b0;
    chk("R10", "fwdValid", fwdValid, 1);
    chk("R10", "updDone", updDone, 1);
    chk("R10", "updErr", updErr, 0);
    doLk("R10", mk(61, 21), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testHitMiss();
    testFullSet();
    testDealloc();
    testDup();
    testSameSet();
    testDiffSet();
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule